// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block is one pulse-width channel whose counter climbs from zero to a programmed top value and then falls back to zero. The result is a pulse centred in each period, and one full period lasts twice the programmed top value in counting ticks. An upstream prescaler supplies a one-cycle tick strobe, and the counter moves only on cycles where that strobe is high.

Software writes a top (period) value and a compare (duty) value. These writes land in shadow registers, and the shadow values can be read back on two output ports. The counter and the comparator work from active copies. The active copies take the shadow contents only when the count arrives at zero, or on the first enabled cycle. A running period therefore never sees a half-applied change.

A polarity input selects the level the pin holds at the start of each period. The pin changes to the opposite level when the rising count meets the duty value. It changes back when the falling count meets the duty value again.

Top module: `capwm_top`

## Requirements
- R1: While reset is asserted, the count output is 0, the pin is 0 and both shadow read ports are 0.
- R2: While the channel enable is low, the count output is 0 one cycle later and the pin is the inverse of the polarity input.
- R3: The count changes only on cycles where the tick input is high. On cycles without a tick, it either holds or, when the channel is disabled, returns to 0.
- R4: On each tick the count steps by one, upward from 0 until it reaches the active period value and then downward to 0. The cycle repeats, so one period spans 2 × period ticks and the count never exceeds the active period.
- R5: At count 0 the pin shows the start level, which equals the polarity input. While counting up, the pin shows the opposite level from the tick where the count equals the duty value. While counting down, the pin shows the opposite level only while the count is above the duty value.
- R6: A period write or a duty write stores the 8-bit write data in that shadow register. The stored value appears on its read port one cycle later.
- R7: Shadow values are copied to the active registers only on the tick that brings the count down to 0 (or at enable). A write in mid-period leaves the rest of the current period unchanged.
- R8: With an active duty value at or above the active period, the pin stays at the start level for the whole period. With a duty of 0, it stays at the opposite level.
- R9: With an active period of 0, the count stays at 0 and the pin stays constant. The shadow is reloaded on every tick, so a later nonzero period takes effect on the next tick.
- R10: On the first enabled cycle after a disabled one, the shadow values become active at once, the count is 0 and counting starts on the next tick.
- R11: With polarity input 1 the period starts high. With polarity input 0 the whole waveform is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count strobe from the prescaler |
| chanEn | input | 1 | Channel enable |
| polHigh | input | 1 | Start level of each period (1 = high) |
| perWr | input | 1 | Write strobe for the shadow period |
| dutyWr | input | 1 | Write strobe for the shadow duty |
| wrData | input | 8 | Write data for both shadow registers |
| pwmOut | output | 1 | PWM pin |
| cntOut | output | 8 | Current counter value |
| perShadow | output | 8 | Shadow period read-back |
| dutyShadow | output | 8 | Shadow duty read-back |

## Verification
The counter is visible at the ports, so a wrong direction bit or a wrong step shows up on the count output at the very next tick. A reload at the wrong moment shows on the pin as an edge displaced within the same period, or as a turnaround at the wrong top value, within at most 2 × period ticks. A stale enable history shows as a missing reload on the first enabled cycle. Every cycle's count, pin level and shadow read-back is compared against an independent model, so a divergence is reported in the cycle where it first appears.

// File: rtl/capwm_pkg.sv
package capwm_pkg;

  // Strobes passed from the control unit to the datapath every cycle.
  typedef struct packed {
    logic idle;      // channel off: pin to inactive level
    logic clear;     // force count to zero
    logic load;      // copy shadow registers into active registers
    logic stepUp;    // count + 1
    logic stepDown;  // count - 1
    logic nextDown;  // direction that holds after this cycle
  } pwmStrobe_t;

endpackage

// File: rtl/capwm_ctrl.sv
module capwm_ctrl
  import capwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       chanEn,
  input  logic       atTop,
  input  logic       perZero,
  input  logic       cntIsOne,
  output pwmStrobe_t strb
);

  logic dirDown;
  logic wasEn;

  always_comb begin
    strb          = '0;
    strb.nextDown = dirDown;
    if (!chanEn) begin
      strb.idle     = 1'b1;
      strb.clear    = 1'b1;
      strb.nextDown = 1'b0;
    end else if (!wasEn) begin
      strb.load     = 1'b1;
      strb.clear    = 1'b1;
      strb.nextDown = 1'b0;
    end else if (tickEn) begin
      if (perZero) begin
        strb.load = 1'b1;
      end else if (!dirDown && !atTop) begin
        strb.stepUp = 1'b1;
      end else begin
        strb.stepDown = 1'b1;
        if (cntIsOne) begin
          strb.load     = 1'b1;
          strb.nextDown = 1'b0;
        end else begin
          strb.nextDown = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirDown <= 1'b0;
      wasEn   <= 1'b0;
    end else begin
      dirDown <= strb.nextDown;
      wasEn   <= chanEn;
    end
  end

  // R4: never step in both directions in one cycle
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDown}));

  // R4: after a downward step that did not reach zero, the count keeps falling
  p_keep_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepDown && !cntIsOne && chanEn) |=> dirDown);

  // R10: the first enabled cycle always reloads
  p_enable_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !wasEn) |-> strb.load);

endmodule

// File: rtl/capwm_dpath.sv
module capwm_dpath
  import capwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic             polHigh,
  input  logic             perWr,
  input  logic             dutyWr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             pwmQ,
  output logic [CNT_W-1:0] shPerQ,
  output logic [CNT_W-1:0] shDutyQ,
  output logic             atTop,
  output logic             perZero,
  output logic             cntIsOne
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] actPerQ, actDutyQ;
  logic [CNT_W-1:0] nxtCnt, nxtPer, nxtDuty;
  logic             dutyLive, pastDuty, pwmNext;

  // Compare flags for the control unit
  assign atTop    = (cntQ >= actPerQ);
  assign perZero  = (actPerQ == '0);
  assign cntIsOne = (cntQ == ONE);

  // Next-state datapath
  always_comb begin
    if (strb.clear)         nxtCnt = '0;
    else if (strb.stepUp)   nxtCnt = cntQ + ONE;
    else if (strb.stepDown) nxtCnt = cntQ - ONE;
    else                    nxtCnt = cntQ;
    nxtPer  = strb.load ? shPerQ  : actPerQ;
    nxtDuty = strb.load ? shDutyQ : actDutyQ;
  end

  // Pin level follows the duty compare on the upward and downward slope
  always_comb begin
    dutyLive = (nxtDuty != '0) && (nxtDuty < nxtPer);
    pastDuty = strb.nextDown ? (nxtCnt > nxtDuty) : (nxtCnt >= nxtDuty);
    if (strb.idle)                 pwmNext = ~polHigh;
    else if (nxtDuty == '0)        pwmNext = ~polHigh;
    else if (dutyLive && pastDuty) pwmNext = ~polHigh;
    else                           pwmNext = polHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      pwmQ     <= 1'b0;
      actPerQ  <= '0;
      actDutyQ <= '0;
    end else begin
      cntQ     <= nxtCnt;
      pwmQ     <= pwmNext;
      actPerQ  <= nxtPer;
      actDutyQ <= nxtDuty;
    end
  end

  // Shadow registers: software side only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPerQ  <= '0;
      shDutyQ <= '0;
    end else begin
      if (perWr)  shPerQ  <= wrData;
      if (dutyWr) shDutyQ <= wrData;
    end
  end

  // R4: count never exceeds the active period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= actPerQ);

  // R7: active registers move only on a load strobe
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(actPerQ) && $stable(actDutyQ)));

  // R2: idle cycle leaves the counter at zero and the pin inactive
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> (cntQ == '0 && pwmQ == !$past(polHigh)));

  // R9: a zero period keeps the count at zero
  p_zero_period_r9: assert property (@(posedge clk) disable iff (!rstN)
    (perZero && !strb.load) |=> cntQ == '0);

endmodule

// File: rtl/capwm_top.sv
module capwm_top
  import capwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             chanEn,
  input  logic             polHigh,
  input  logic             perWr,
  input  logic             dutyWr,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cntOut,
  output logic [CNT_W-1:0] perShadow,
  output logic [CNT_W-1:0] dutyShadow
);

  pwmStrobe_t strb;
  logic       atTop, perZero, cntIsOne;

  capwm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .chanEn   (chanEn),
    .atTop    (atTop),
    .perZero  (perZero),
    .cntIsOne (cntIsOne),
    .strb     (strb)
  );

  capwm_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .polHigh  (polHigh),
    .perWr    (perWr),
    .dutyWr   (dutyWr),
    .wrData   (wrData),
    .cntQ     (cntOut),
    .pwmQ     (pwmOut),
    .shPerQ   (perShadow),
    .shDutyQ  (dutyShadow),
    .atTop    (atTop),
    .perZero  (perZero),
    .cntIsOne (cntIsOne)
  );

  // R6: a period write is visible on the read port next cycle
  p_shadow_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    perWr |=> perShadow == $past(wrData));

  // R3: without a tick the count holds or clears to zero
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (cntOut == '0 || $stable(cntOut)));

endmodule

// File: tb/capwm_tb.sv
module capwm_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0, chanEn = 1'b0, polHigh = 1'b1;
  logic       perWr = 1'b0, dutyWr = 1'b0;
  logic [7:0] wrData = '0;
  logic       pwmOut;
  logic [7:0] cntOut, perShadow, dutyShadow;

  capwm_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chanEn(chanEn),
    .polHigh(polHigh), .perWr(perWr), .dutyWr(dutyWr), .wrData(wrData),
    .pwmOut(pwmOut), .cntOut(cntOut), .perShadow(perShadow),
    .dutyShadow(dutyShadow)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] c;
    logic       o;
    logic [7:0] sp;
    logic [7:0] sd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nVec = 0;
  int   nBad = 0;
  bit   done = 0;

  // Reference model state (built from the requirements)
  logic [7:0] mCnt = 0, mPer = 0, mDuty = 0, mShP = 0, mShD = 0;
  logic       mDown = 0, mWas = 0, mOut = 0;

  task automatic step(input logic te, input logic en, input logic pol,
                      input logic pw, input logic dw, input logic [7:0] d,
                      input string tag);
    logic       load, act;
    logic [7:0] nc, np, nd;
    logic       ndn;
    exp_t       e;
    tickEn = te; chanEn = en; polHigh = pol; perWr = pw; dutyWr = dw; wrData = d;
    load = 0; nc = mCnt; ndn = mDown;
    if (!en) begin
      nc = 0; ndn = 0; np = mPer; nd = mDuty;
      mOut = ~pol;
    end else begin
      if (!mWas) begin
        load = 1; nc = 0; ndn = 0;
      end else if (te) begin
        if (mPer == 0) load = 1;
        else if (!mDown && mCnt < mPer) nc = mCnt + 1;
        else begin
          nc = mCnt - 1;
          if (nc == 0) begin load = 1; ndn = 0; end
          else ndn = 1;
        end
      end
      np = load ? mShP : mPer;
      nd = load ? mShD : mDuty;
      act = (nd == 0) || ((nd < np) && (ndn ? (nc > nd) : (nc >= nd)));
      mOut = act ? ~pol : pol;
    end
    mCnt = nc; mDown = ndn; mPer = np; mDuty = nd; mWas = en;
    if (pw) mShP = d;
    if (dw) mShD = d;
    e.c = mCnt; e.o = mOut; e.sp = mShP; e.sd = mShD; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Run n cycles with a tick every 'every' cycles, no writes
  task automatic run(input int n, input int every, input logic en,
                     input logic pol, input string tag);
    for (int i = 0; i < n; i++)
      step((i % every) == 0, en, pol, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic wrP(input logic [7:0] v, input logic en, input logic pol,
                     input string tag);
    step(1'b1, en, pol, 1'b1, 1'b0, v, tag);
  endtask

  task automatic wrD(input logic [7:0] v, input logic en, input logic pol,
                     input string tag);
    step(1'b1, en, pol, 1'b0, 1'b1, v, tag);
  endtask

  // Monitor: compare each cycle's outputs against the queued expectation
  always begin
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nVec++;
      if (cntOut !== e.c || pwmOut !== e.o || perShadow !== e.sp ||
          dutyShadow !== e.sd) begin
        nBad++;
        $display("FAIL %s: cnt=%0d/%0d pin=%0b/%0b shP=%0d/%0d shD=%0d/%0d (actual/expected)",
                 e.tag, cntOut, e.c, pwmOut, e.o, perShadow, e.sp,
                 dutyShadow, e.sd);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nVec++;
    if (cntOut !== 8'd0 || pwmOut !== 1'b0 || perShadow !== 8'd0 ||
        dutyShadow !== 8'd0) begin
      nBad++;
      $display("FAIL R1: cnt=%0d pin=%0b shP=%0d shD=%0d expected all 0",
               cntOut, pwmOut, perShadow, dutyShadow);
    end
    rstN = 1'b1;
    run(4, 1, 1'b0, 1'b1, "R2 idle pol1");
    run(3, 1, 1'b0, 1'b0, "R2 idle pol0");
    wrP(8'd4, 1'b0, 1'b1, "R6 period write");
    wrD(8'd1, 1'b0, 1'b1, "R6 duty write");
    run(2, 1, 1'b0, 1'b1, "R7 disabled no load");
    run(1, 1, 1'b1, 1'b1, "R10 enable load");
    run(20, 1, 1'b1, 1'b1, "R4 R5 up/down");
    run(30, 3, 1'b1, 1'b1, "R3 sparse ticks");
    wrP(8'd6, 1'b1, 1'b1, "R7 mid write per");
    wrD(8'd3, 1'b1, 1'b1, "R7 mid write duty");
    run(40, 1, 1'b1, 1'b1, "R7 reload at zero");
    wrD(8'd6, 1'b1, 1'b1, "R8 duty eq period");
    run(30, 1, 1'b1, 1'b1, "R8 duty>=period");
    wrD(8'd9, 1'b1, 1'b1, "R8 duty above");
    run(26, 1, 1'b1, 1'b1, "R8 duty above period");
    wrD(8'd0, 1'b1, 1'b1, "R8 duty zero");
    run(30, 1, 1'b1, 1'b1, "R8 duty zero");
    wrD(8'd2, 1'b1, 1'b0, "R11 pol0");
    run(30, 1, 1'b1, 1'b0, "R11 inverted");
    wrP(8'd0, 1'b1, 1'b1, "R9 period zero");
    run(20, 1, 1'b1, 1'b1, "R9 hold zero");
    wrP(8'd1, 1'b1, 1'b1, "R9 restart");
    run(10, 1, 1'b1, 1'b1, "R4 period one");
    wrP(8'd5, 1'b1, 1'b1, "R4 period five");
    run(14, 2, 1'b1, 1'b1, "R4 R5 period five");
    run(3, 1, 1'b0, 1'b1, "R2 disable mid run");
    wrP(8'd3, 1'b0, 1'b0, "R6 write while off");
    run(1, 1, 1'b1, 1'b0, "R10 re-enable");
    run(16, 1, 1'b1, 1'b0, "R10 first period");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule